// File: doc/BRIEF.md
# Smartcard Character-Mode UART

This block is an asynchronous serial transceiver for a card link that runs in character mode over one shared open-drain data line. Every character is a low start bit, eight data bits sent least significant bit first, an even parity bit and a stop period of one and a half bit times. All bit timing is taken from an external tick that pulses once per clock cycle at sixteen times the baud rate, so one bit lasts 16 ticks and half a bit lasts 8.

When the receiver finds bad parity, it reports the byte with an error flag. It also pulls the line low for one bit time in the guard period after the character, which tells the sender to repeat it. When the transmitter sends a character, it watches the line during its own stop period and flags the character if the far end pulls the line low there. The link is half-duplex. While one direction is busy the other stays idle, so the receiver never reports the block's own characters. A programmable divided clock can be driven toward the card.

Top module: `sc_uart`

## Requirements
- R1: After reset the line is released (line_oe = 0), tx_ready = 1, rx_valid = 0 and card_clk = 0.
- R2: A byte accepted on tx_valid with tx_ready high is sent as a low start bit, then data bits 0 to 7, then a parity bit chosen so the nine data and parity bits hold an even number of ones. Each bit lasts 16 baud ticks counted from the accepting clock edge, and line_oe = 1 means the line is pulled low.
- R3: After the parity bit the transmitter releases the line for 24 ticks. It then pulses tx_done for one cycle and raises tx_ready again.
- R4: If the line is low at the 16th tick of the transmit stop period, tx_err is 1 when tx_done pulses. Otherwise it is 0.
- R5: A received character with correct even parity produces a one-cycle rx_valid pulse with rx_data holding the byte and rx_perr = 0, issued near the middle of the parity bit.
- R6: A received character with wrong parity is reported with rx_perr = 1. The receiver then pulls the line low for 16 ticks, starting 16 ticks after it samples parity, which is about half a bit after the parity bit ends. It releases the line before and after that window.
- R7: With cfg_rx_half_stop = 1, the receiver accepts a new start bit half a bit after the parity bit ends, so characters with a 0.5-bit stop period are received back to back.
- R8: A low pulse on an idle line that is gone by the middle of the start bit is ignored and produces no rx_valid.
- R9: Characters on the line while the transmitter is busy produce no rx_valid. tx_ready stays low while a character is being received.
- R10: With cfg_clk_en = 1, card_clk has a period of 2*(cfg_clk_div+1) clock cycles and is high for half of it. With cfg_clk_en = 0 it is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the baud rate |
| cfg_rx_half_stop | input | 1 | Receiver uses a 0.5-bit stop period |
| cfg_clk_en | input | 1 | Enable the card clock output |
| cfg_clk_div | input | 8 | Card clock half period minus one, in clock cycles |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block can accept a byte |
| tx_done | output | 1 | One-cycle pulse at the end of a transmitted character |
| tx_err | output | 1 | Far end signalled an error for the last character |
| rx_valid | output | 1 | One-cycle pulse: a byte was received |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Received byte had a parity error |
| line_in | input | 1 | Level of the shared data line |
| line_oe | output | 1 | 1 pulls the shared data line low |
| card_clk | output | 1 | Divided clock toward the card |

## Verification
A transmit bit counter that is off by one shifts every later bit by 16 ticks. The bench then reads the frame one bit out of place within a single character, and tx_done moves away from tick 184. A receive state that slips sends the error pulse outside its window, which the bench sees at line_oe within the next 32 ticks. It can also mis-assemble rx_data, which the bench sees at the rx_valid of that same character. A wrong half-duplex interlock produces echo bytes on rx_valid during the bench's own transmissions. A wrong divider count changes the card_clk period measured over a single cycle.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_GUARD
  } rx_state_e;
endpackage

// File: rtl/sc_clk_div.sv
module sc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!en_i) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign clk_o = lvl_q;

  AST_CLK_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !clk_o); // R10
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              drive_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CW     = $clog2(2 * OVS);
  localparam int IW     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int STOP_T = OVS + OVS / 2;

  tx_state_e         state_q, state_d;
  logic [CW-1:0]     tk_q, tk_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              drv_q, drv_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              bit_end;

  assign bit_end = tick_i && (tk_q == CW'(OVS - 1));

  always_comb begin
    state_d = state_q;
    tk_d    = tk_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    drv_d   = drv_q;
    err_d   = err_q;
    done_d  = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (start_i) begin
          sh_d    = data_i;
          par_d   = ^data_i;
          tk_d    = '0;
          drv_d   = 1'b1;
          err_d   = 1'b0;
          state_d = TX_START;
        end
      end
      TX_START: begin
        if (bit_end) begin
          tk_d    = '0;
          idx_d   = '0;
          drv_d   = ~sh_q[0];
          state_d = TX_DATA;
        end else if (tick_i) begin
          tk_d = tk_q + 1'b1;
        end
      end
      TX_DATA: begin
        if (bit_end) begin
          tk_d = '0;
          if (idx_q == IW'(DATA_W - 1)) begin
            drv_d   = ~par_q;
            state_d = TX_PAR;
          end else begin
            idx_d = idx_q + 1'b1;
            sh_d  = sh_q >> 1;
            drv_d = ~sh_q[1];
          end
        end else if (tick_i) begin
          tk_d = tk_q + 1'b1;
        end
      end
      TX_PAR: begin
        if (bit_end) begin
          tk_d    = '0;
          drv_d   = 1'b0;
          state_d = TX_STOP;
        end else if (tick_i) begin
          tk_d = tk_q + 1'b1;
        end
      end
      TX_STOP: begin
        if (tick_i) begin
          if (tk_q == CW'(OVS - 1) && !line_i) begin
            err_d = 1'b1;
          end
          if (tk_q == CW'(STOP_T - 1)) begin
            tk_d    = '0;
            done_d  = 1'b1;
            state_d = TX_IDLE;
          end else begin
            tk_d = tk_q + 1'b1;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      tk_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      drv_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tk_q    <= tk_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      drv_q   <= drv_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q != TX_IDLE);
  assign drive_o = drv_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  AST_TX_START_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == TX_IDLE) |=> drive_o); // R2
  AST_TX_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_STOP) |-> !drive_o); // R3
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_q == TX_IDLE && !drive_o)); // R3
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              half_stop_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              nack_o
);
  localparam int CW      = $clog2(2 * OVS);
  localparam int IW      = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF    = OVS / 2;
  localparam int GUARD_T = 2 * OVS;

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     tk_q, tk_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              perr_q, perr_d;
  logic              vld_q, vld_d;
  logic              nack_q, nack_d;
  logic              bit_end;

  assign bit_end = tick_i && (tk_q == CW'(OVS - 1));

  always_comb begin
    state_d = state_q;
    tk_d    = tk_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    dat_d   = dat_q;
    perr_d  = perr_q;
    nack_d  = nack_q;
    vld_d   = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (en_i && tick_i && !line_i) begin
          tk_d    = '0;
          state_d = RX_START;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (tk_q == CW'(HALF - 1)) begin
            tk_d    = '0;
            idx_d   = '0;
            state_d = line_i ? RX_IDLE : RX_DATA;
          end else begin
            tk_d = tk_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (bit_end) begin
          tk_d = '0;
          sh_d = {line_i, sh_q[DATA_W-1:1]};
          if (idx_q == IW'(DATA_W - 1)) begin
            state_d = RX_PAR;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (tick_i) begin
          tk_d = tk_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (bit_end) begin
          tk_d    = '0;
          dat_d   = sh_q;
          perr_d  = (^sh_q) ^ line_i;
          vld_d   = 1'b1;
          state_d = RX_GUARD;
        end else if (tick_i) begin
          tk_d = tk_q + 1'b1;
        end
      end
      RX_GUARD: begin
        if (tick_i) begin
          if (tk_q == CW'(GUARD_T - 1)) begin
            tk_d    = '0;
            nack_d  = 1'b0;
            state_d = RX_IDLE;
          end else if (tk_q == CW'(OVS - 1) && perr_q) begin
            nack_d = 1'b1;
            tk_d   = tk_q + 1'b1;
          end else if (tk_q == CW'(OVS - 1) && half_stop_i) begin
            tk_d    = '0;
            state_d = RX_IDLE;
          end else begin
            tk_d = tk_q + 1'b1;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tk_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      dat_q   <= '0;
      perr_q  <= 1'b0;
      vld_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tk_q    <= tk_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      dat_q   <= dat_d;
      perr_q  <= perr_d;
      vld_q   <= vld_d;
      nack_q  <= nack_d;
    end
  end

  assign busy_o  = (state_q != RX_IDLE);
  assign valid_o = vld_q;
  assign data_o  = dat_q;
  assign perr_o  = perr_q;
  assign nack_o  = nack_q;

  AST_RX_NACK_NEEDS_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> perr_o); // R6
  AST_RX_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R5
  AST_RX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && state_q == RX_IDLE) |=> (state_q == RX_IDLE)); // R9
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_rx_half_stop,
  input  logic              cfg_clk_en,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_done,
  output logic              tx_err,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  input  logic              line_in,
  output logic              line_oe,
  output logic              card_clk
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic [1:0] line_sync_q;
  logic       line_s;
  logic       tx_busy, rx_busy, tx_start, rx_en;
  logic       tx_drive, rx_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) line_sync_q <= 2'b11;
    else          line_sync_q <= {line_sync_q[0], line_in};
  end
  assign line_s = line_sync_q[1];

  assign tx_ready = !tx_busy && !rx_busy;
  assign tx_start = tx_valid && tx_ready;
  assign rx_en    = !tx_busy && !tx_start;

  sc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_i  (baud_tick),
    .start_i (tx_start),
    .data_i  (tx_data),
    .line_i  (line_s),
    .busy_o  (tx_busy),
    .drive_o (tx_drive),
    .done_o  (tx_done),
    .err_o   (tx_err)
  );

  sc_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tick_i      (baud_tick),
    .en_i        (rx_en),
    .half_stop_i (cfg_rx_half_stop),
    .line_i      (line_s),
    .busy_o      (rx_busy),
    .valid_o     (rx_valid),
    .data_o      (rx_data),
    .perr_o      (rx_perr),
    .nack_o      (rx_nack)
  );

  sc_clk_div #(.DIV_W(DIV_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en_i  (cfg_clk_en),
    .div_i (cfg_clk_div),
    .clk_o (card_clk)
  );

  assign line_oe = tx_drive | rx_nack;

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(tx_busy && rx_busy)); // R9
endmodule

// File: tb/sc_uart_tb.sv
module sc_uart_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_rx_half_stop = 1'b0;
  logic       cfg_clk_en = 1'b0;
  logic [7:0] cfg_clk_div = 8'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tb_low = 1'b0;
  logic       tx_ready, tx_done, tx_err, rx_valid, rx_perr, line_oe, card_clk;
  logic [7:0] rx_data;
  logic       line;

  int checks = 0;
  int errors = 0;
  int tick_div = 0;
  int rx_cnt = 0;
  int done_cnt = 0;
  logic [7:0] rx_last = 8'd0, rx_prev = 8'd0;
  logic       rx_last_perr = 1'b0;
  logic       done_err = 1'b0;

  assign line = ~(line_oe | tb_low);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == 3);
    if (rx_valid) begin
      rx_cnt       <= rx_cnt + 1;
      rx_prev      <= rx_last;
      rx_last      <= rx_data;
      rx_last_perr <= rx_perr;
    end
    if (tx_done) begin
      done_cnt <= done_cnt + 1;
      done_err <= tx_err;
    end
  end

  sc_uart u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_rx_half_stop(cfg_rx_half_stop), .cfg_clk_en(cfg_clk_en),
    .cfg_clk_div(cfg_clk_div), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_err(tx_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .line_in(line), .line_oe(line_oe), .card_clk(card_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(line_oe == 1'b0, "R1 line in reset", int'(line_oe), 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(line_oe == 1'b0 && tx_ready == 1'b1 && rx_valid == 1'b0 && card_clk == 1'b0,
        "R1 idle outputs", int'({line_oe, tx_ready, rx_valid, card_clk}), 4'b0100);
  endtask

  // R2 R3 R4 R9: send one byte, decode the line, optionally signal error
  task automatic t_send(input logic [7:0] d, input bit nack);
    logic [9:0] obs, exp;
    int d0, r0;
    d0 = done_cnt;
    r0 = rx_cnt;
    exp = {^d, d, 1'b0};
    @(negedge clk);
    chk(tx_ready == 1'b1, "R3 ready before send", int'(tx_ready), 1);
    tx_valid = 1'b1;
    tx_data  = d;
    @(posedge clk);
    #1;
    tx_valid = 1'b0;
    wait_ticks(8);
    obs[0] = ~line_oe;
    for (int k = 1; k < 10; k++) begin
      wait_ticks(16);
      obs[k] = ~line_oe;
    end
    chk(obs == exp, "R2 frame bits", int'(obs), int'(exp));
    wait_ticks(12);
    chk(line_oe == 1'b0, "R3 stop released", int'(line_oe), 0);
    wait_ticks(4);
    if (nack) tb_low = 1'b1;
    wait_ticks(12);
    chk(done_cnt == d0, "R3 no early done", done_cnt, d0);
    wait_ticks(4);
    tb_low = 1'b0;
    wait_ticks(2);
    chk(done_cnt == d0 + 1, "R3 done pulse", done_cnt, d0 + 1);
    chk(done_err == nack, "R4 tx_err", int'(done_err), int'(nack));
    chk(tx_ready == 1'b1, "R3 ready after", int'(tx_ready), 1);
    chk(rx_cnt == r0, "R9 no echo", rx_cnt, r0);
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit bad, input int stop_t);
    logic p;
    p = (^d) ^ bad;
    wait_ticks(1);
    tb_low = 1'b1;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      tb_low = ~d[i];
      wait_ticks(16);
    end
    tb_low = ~p;
    wait_ticks(16);
    tb_low = 1'b0;
    if (stop_t > 0) wait_ticks(stop_t);
  endtask

  task automatic t_rx_ok(input logic [7:0] d);
    int r0;
    r0 = rx_cnt;
    fork
      drive_frame(d, 1'b0, 24);
      begin
        wait_ticks(40);
        chk(tx_ready == 1'b0, "R9 ready low in rx", int'(tx_ready), 0);
      end
    join
    chk(rx_cnt == r0 + 1, "R5 rx count", rx_cnt, r0 + 1);
    chk(rx_last == d && rx_last_perr == 1'b0, "R5 rx byte",
        int'({rx_last_perr, rx_last}), int'({1'b0, d}));
    chk(line_oe == 1'b0, "R5 no error signal", int'(line_oe), 0);
  endtask

  task automatic t_rx_bad(input logic [7:0] d);
    int r0;
    r0 = rx_cnt;
    drive_frame(d, 1'b1, 0);
    chk(rx_cnt == r0 + 1 && rx_last_perr == 1'b1, "R6 perr flagged",
        int'(rx_last_perr), 1);
    chk(rx_last == d, "R6 data kept", int'(rx_last), int'(d));
    wait_ticks(2);
    chk(line_oe == 1'b0, "R6 released before window", int'(line_oe), 0);
    wait_ticks(14);
    chk(line_oe == 1'b1, "R6 error pulse", int'(line_oe), 1);
    wait_ticks(14);
    chk(line_oe == 1'b0, "R6 released after window", int'(line_oe), 0);
    wait_ticks(10);
  endtask

  task automatic t_half_stop();
    int r0;
    r0 = rx_cnt;
    cfg_rx_half_stop = 1'b1;
    drive_frame(8'h5A, 1'b0, 8);
    drive_frame(8'h81, 1'b0, 24);
    chk(rx_cnt == r0 + 2, "R7 two bytes", rx_cnt, r0 + 2);
    chk(rx_prev == 8'h5A && rx_last == 8'h81, "R7 back to back data",
        int'({rx_prev, rx_last}), 16'h5A81);
    cfg_rx_half_stop = 1'b0;
  endtask

  task automatic t_false_start();
    int r0;
    r0 = rx_cnt;
    wait_ticks(1);
    tb_low = 1'b1;
    wait_ticks(3);
    tb_low = 1'b0;
    wait_ticks(200);
    chk(rx_cnt == r0, "R8 glitch ignored", rx_cnt, r0);
    chk(tx_ready == 1'b1, "R8 back to idle", int'(tx_ready), 1);
  endtask

  task automatic t_card_clk(input logic [7:0] div);
    int per, hi;
    logic prev;
    @(negedge clk);
    cfg_clk_div = div;
    cfg_clk_en  = 1'b1;
    prev = card_clk;
    @(negedge clk);
    while (!(prev == 1'b0 && card_clk == 1'b1)) begin
      prev = card_clk;
      @(negedge clk);
    end
    per = 0;
    hi  = 0;
    do begin
      if (card_clk) hi++;
      per++;
      prev = card_clk;
      @(negedge clk);
    end while (!(prev == 1'b0 && card_clk == 1'b1));
    chk(per == 2 * (div + 1), "R10 period", per, 2 * (div + 1));
    chk(hi == div + 1, "R10 high time", hi, div + 1);
    cfg_clk_en = 1'b0;
    repeat (2) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (card_clk) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R10 held low", hi, 0);
  endtask

  initial begin
    t_reset();
    t_send(8'hA5, 1'b0);
    t_send(8'h00, 1'b0);
    t_send(8'hFF, 1'b1);
    t_send(8'h37, 1'b0);
    t_rx_ok(8'h3C);
    t_rx_bad(8'hC1);
    t_half_stop();
    t_false_start();
    t_rx_ok(8'h01);
    t_card_clk(8'd2);
    t_card_clk(8'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule